// File: doc/BRIEF.md
# Burst-Tolerant Interleaved SEC Row Codec

This block protects one wide memory row against radiation upsets. On the write side it splits the data word into a set of independent lanes, computes single-error-correcting check bits for each lane, and presents a full row to a registered store port. In that row the data bits and the check bits occupy separate fields. The lanes are interleaved bit by bit, so that neighbouring physical cells always belong to different lanes. On the read side it undoes the interleave, computes one syndrome per lane, repairs one flipped bit in each lane, and reports which lanes were repaired and whether any lane held damage it could not locate.

Because physical bit `i` belongs to lane `i mod LANES`, any contiguous run of up to `LANES` flipped cells hits each lane at most once. Each flip is therefore a single error inside its own codeword and is corrected. The large configuration (4096 data bits in 8 lanes of 512 bits, 10 check bits per lane) and small test configurations come from the same parameters.

Top module: `bih_row_codec`

## Requirements
- R1: `st_we` is 0 out of reset and is 1 exactly in the cycle after a cycle with `wr_en` = 1. `st_row` is updated at that same edge.
- R2: The data field of the stored row is the write data unchanged: `st_row[DATA_W-1:0]` equals `wr_data`. Physical data bit `j` belongs to lane `j mod LANES` as lane data bit `j / LANES`.
- R3: Lane `l` check bit `c` is stored at physical bit `DATA_W + c*LANES + l`. It is the XOR of the lane data bits `d` whose column code has bit `c` set. The column code of lane data bit `d` is the `d`-th integer (counting from 0) that is at least 3 and is not a power of two.
- R4: `rd_valid` is 1 exactly in the cycle after a cycle with `rd_en` = 1, and all read outputs are valid in that cycle. For a clean row, `rd_data` equals the stored data field, `rd_corr` is 0 and `rd_uncorr` is 0.
- R5: A single flipped bit at any physical position of the row, data or check, is corrected. `rd_data` returns the original data and `rd_corr` has exactly bit `(position mod LANES)` set.
- R6: Any contiguous run of 1 to `LANES` flipped physical bits within the row is corrected. `rd_corr` has a bit set for each lane the run touches and `rd_uncorr` is 0.
- R7: A lane whose nonzero syndrome is neither a power of two nor any data column code sets `rd_uncorr`. That lane's `rd_corr` bit stays 0 and its data bits are passed through unmodified. Other lanes in the same row are still corrected. For example, in the default setup, flipping check bits 0, 2 and 3 of one lane gives syndrome 13.
- R8: In a cycle after one without `rd_en`, `rd_valid`, `rd_corr` and `rd_uncorr` are 0. `rd_data` holds its last value whatever `rd_row` does.
- R9: After reset, `st_row`, `rd_data`, `rd_corr`, `rd_uncorr`, `st_we` and `rd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Encode `wr_data` and present it on the store port next cycle |
| wr_data | input | DATA_W | Data word to protect |
| st_we | output | 1 | Store strobe toward the row array |
| st_row | output | DATA_W + LANES*CHK | Interleaved row: data field low, check field high |
| rd_en | input | 1 | Decode `rd_row` this cycle |
| rd_row | input | DATA_W + LANES*CHK | Row read back from the array |
| rd_valid | output | 1 | Read results valid |
| rd_data | output | DATA_W | Corrected data |
| rd_corr | output | LANES | Per-lane corrected flag |
| rd_uncorr | output | 1 | Some lane held an unlocatable error |

## Verification
The bench builds the block with 64 data bits in 8 lanes, which gives 8 data bits and 4 check bits per lane and a 96-bit row. At this size every single-flip position and every burst of length 1 to 8 at every start position in the row can be read back and checked exhaustively. The same size leaves syndrome values 13 to 15 unused, so the unlocatable-error path can be reached on purpose by flipping chosen check bits.

// File: rtl/bih_pkg.sv
package bih_pkg;

   // Smallest check-bit count r with 2^r >= dw + r + 1 (single error correction).
   function automatic int chk_bits(input int dw);
      int r;
      r = 1;
      while ((1 << r) < (dw + r + 1)) r++;
      return r;
   endfunction

   // Column code of data bit d: the d-th integer >= 3 that is not a power of two.
   function automatic int col_code(input int d);
      int v;
      int n;
      v = 2;
      n = -1;
      while (n < d) begin
         v++;
         if ((v & (v - 1)) != 0) n++;
      end
      return v;
   endfunction

endpackage

// File: rtl/bih_lane_enc.sv
module bih_lane_enc #(
   parameter int DW  = 8,
   parameter int CHK = bih_pkg::chk_bits(DW)
) (
   input  logic [DW-1:0]  din,
   output logic [CHK-1:0] chk
);

   logic [CHK-1:0] col [DW];

   // elaboration check: check width must cover the lane
   if ((1 << CHK) < (DW + CHK + 1)) begin : g_bad_chk
      $error("bih_lane_enc: CHK too small for DW");
   end

   for (genvar g = 0; g < DW; g++) begin : g_col
      assign col[g] = CHK'(bih_pkg::col_code(g));
   end

   always_comb begin
      chk = '0;
      for (int i = 0; i < DW; i++) begin
         if (din[i]) chk = chk ^ col[i];
      end
   end

endmodule

// File: rtl/bih_lane_dec.sv
module bih_lane_dec #(
   parameter int DW  = 8,
   parameter int CHK = bih_pkg::chk_bits(DW)
) (
   input  logic [DW-1:0]  din,
   input  logic [CHK-1:0] chk_in,
   output logic [DW-1:0]  dout,
   output logic           corr,
   output logic           uncorr
);

   logic [CHK-1:0] recomputed;
   logic [CHK-1:0] syn;
   logic [CHK-1:0] col [DW];
   logic [DW-1:0]  hit;
   logic           chk_hit;

   bih_lane_enc #(.DW(DW), .CHK(CHK)) i_reenc (
      .din (din),
      .chk (recomputed)
   );

   assign syn = recomputed ^ chk_in;

   for (genvar g = 0; g < DW; g++) begin : g_match
      assign col[g] = CHK'(bih_pkg::col_code(g));
      assign hit[g] = (syn == col[g]);
   end

   // A one-hot syndrome names a flipped check bit; data stays as read.
   assign chk_hit = $onehot(syn);
   assign dout    = din ^ hit;
   assign corr    = (|hit) | chk_hit;
   assign uncorr  = (syn != '0) & ~corr;

endmodule

// File: rtl/bih_perm.sv
module bih_perm #(
   parameter int LANES   = 8,
   parameter int LANE_CW = 12,
   parameter bit TO_PHYS = 1'b1,
   localparam int W      = LANES * LANE_CW
) (
   input  logic [W-1:0] in_v,
   output logic [W-1:0] out_v
);

   // Lane-major index l*LANE_CW+k <-> physical index k*LANES+l
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      for (genvar k = 0; k < LANE_CW; k++) begin : g_bit
         if (TO_PHYS) begin : g_fwd
            assign out_v[k*LANES + l] = in_v[l*LANE_CW + k];
         end else begin : g_rev
            assign out_v[l*LANE_CW + k] = in_v[k*LANES + l];
         end
      end
   end

endmodule

// File: rtl/bih_row_codec.sv
module bih_row_codec #(
   parameter int  DATA_W   = 64,
   parameter int  LANES    = 8,
   localparam int LANE_DW  = DATA_W / LANES,
   localparam int CHK      = bih_pkg::chk_bits(LANE_DW),
   localparam int LANE_CW  = LANE_DW + CHK,
   localparam int ROW_W    = LANES * LANE_CW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              st_we,
   output logic [ROW_W-1:0]  st_row,
   input  logic              rd_en,
   input  logic [ROW_W-1:0]  rd_row,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [LANES-1:0]  rd_corr,
   output logic              rd_uncorr
);

   // ---------------- elaboration checks ----------------
   if (LANES < 2) begin : g_bad_lanes
      $error("bih_row_codec: LANES must be at least 2");
   end
   if ((DATA_W % LANES) != 0) begin : g_bad_split
      $error("bih_row_codec: DATA_W must be a multiple of LANES");
   end
   if (LANE_DW < 1) begin : g_bad_lane_dw
      $error("bih_row_codec: each lane needs at least one data bit");
   end

   // ---------------- write path ----------------
   logic [ROW_W-1:0] enc_lane_major;
   logic [ROW_W-1:0] enc_phys;

   for (genvar l = 0; l < LANES; l++) begin : g_enc
      logic [LANE_DW-1:0] ld;
      logic [CHK-1:0]     lc;
      for (genvar k = 0; k < LANE_DW; k++) begin : g_gather
         assign ld[k] = wr_data[k*LANES + l];
      end
      bih_lane_enc #(.DW(LANE_DW), .CHK(CHK)) i_enc (
         .din (ld),
         .chk (lc)
      );
      assign enc_lane_major[l*LANE_CW +: LANE_CW] = {lc, ld};
   end

   bih_perm #(.LANES(LANES), .LANE_CW(LANE_CW), .TO_PHYS(1'b1)) i_perm_wr (
      .in_v  (enc_lane_major),
      .out_v (enc_phys)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_we  <= 1'b0;
         st_row <= '0;
      end else begin
         st_we <= wr_en;
         if (wr_en) st_row <= enc_phys;
      end
   end

   // ---------------- read path ----------------
   logic [ROW_W-1:0]  rd_lane_major;
   logic [DATA_W-1:0] dec_data;
   logic [LANES-1:0]  lane_corr;
   logic [LANES-1:0]  lane_uncorr;

   bih_perm #(.LANES(LANES), .LANE_CW(LANE_CW), .TO_PHYS(1'b0)) i_perm_rd (
      .in_v  (rd_row),
      .out_v (rd_lane_major)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_dec
      logic [LANE_DW-1:0] ld_in;
      logic [CHK-1:0]     lc_in;
      logic [LANE_DW-1:0] ld_out;
      assign ld_in = rd_lane_major[l*LANE_CW +: LANE_DW];
      assign lc_in = rd_lane_major[l*LANE_CW + LANE_DW +: CHK];
      bih_lane_dec #(.DW(LANE_DW), .CHK(CHK)) i_dec (
         .din    (ld_in),
         .chk_in (lc_in),
         .dout   (ld_out),
         .corr   (lane_corr[l]),
         .uncorr (lane_uncorr[l])
      );
      for (genvar k = 0; k < LANE_DW; k++) begin : g_scatter
         assign dec_data[k*LANES + l] = ld_out[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         rd_corr   <= '0;
         rd_uncorr <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_data   <= dec_data;
            rd_corr   <= lane_corr;
            rd_uncorr <= |lane_uncorr;
         end else begin
            rd_corr   <= '0;
            rd_uncorr <= 1'b0;
         end
      end
   end

   // ---------------- assertions ----------------
   AST_STORE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> st_we); // R1
   AST_NO_STRAY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !st_we); // R1
   AST_DATA_FIELD_VERBATIM: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (st_row[DATA_W-1:0] == $past(wr_data))); // R2
   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid); // R4
   AST_CLEAN_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && lane_corr == '0 && lane_uncorr == '0) |=> (rd_data == $past(rd_row[DATA_W-1:0]))); // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (!rd_valid && rd_corr == '0 && !rd_uncorr && $stable(rd_data))); // R8
   AST_UNCORR_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_uncorr |-> rd_valid); // R7

endmodule

// File: tb/test_bih_row_codec.sv
module test_bih_row_codec;

   localparam int DATA_W  = 64;
   localparam int LANES   = 8;
   localparam int LANE_DW = DATA_W / LANES;
   localparam int CHK     = 4;
   localparam int ROW_W   = DATA_W + LANES * CHK;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              st_we;
   logic [ROW_W-1:0]  st_row;
   logic              rd_en = 1'b0;
   logic [ROW_W-1:0]  rd_row = '0;
   logic              rd_valid;
   logic [DATA_W-1:0] rd_data;
   logic [LANES-1:0]  rd_corr;
   logic              rd_uncorr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bih_row_codec #(.DATA_W(DATA_W), .LANES(LANES)) i_bih_row_codec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .st_we(st_we), .st_row(st_row), .rd_en(rd_en), .rd_row(rd_row),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_corr(rd_corr), .rd_uncorr(rd_uncorr)
   );

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Column code per requirement R3: the d-th value >= 3 that is not a power of two
   function automatic int ref_col(input int d);
      int found;
      found = 0;
      for (int v = 3; v < 1024; v++) begin
         if ((v & (v - 1)) != 0) begin
            if (found == d) return v;
            found++;
         end
      end
      return 0;
   endfunction

   function automatic logic [ROW_W-1:0] ref_encode(input logic [DATA_W-1:0] d);
      logic [ROW_W-1:0] r;
      r = '0;
      r[DATA_W-1:0] = d;
      for (int l = 0; l < LANES; l++) begin
         for (int c = 0; c < CHK; c++) begin
            logic p;
            p = 1'b0;
            for (int k = 0; k < LANE_DW; k++)
               if (((ref_col(k) >> c) & 1) == 1) p = p ^ d[k*LANES + l];
            r[DATA_W + c*LANES + l] = p;
         end
      end
      return r;
   endfunction

   task automatic do_write(input logic [DATA_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [ROW_W-1:0] row);
      @(negedge clk);
      rd_en = 1'b1; rd_row = row;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic test_reset();
      chk(st_we == 0 && rd_valid == 0, "R9 strobes after reset", {st_we, rd_valid}, 0);
      chk(st_row == '0 && rd_data == '0, "R9 data regs after reset", {st_row, rd_data}, 0);
      chk(rd_corr == '0 && rd_uncorr == 0, "R9 flags after reset", {rd_corr, rd_uncorr}, 0);
   endtask

   task automatic test_encode();
      logic [DATA_W-1:0] pats [5];
      pats[0] = '0; pats[1] = '1; pats[2] = 64'hAAAA_5555_F0F0_0F0F;
      pats[3] = 64'h0000_0000_0000_0001; pats[4] = 64'h8123_4567_89AB_CDEF;
      foreach (pats[p]) begin
         do_write(pats[p]);
         chk(st_we == 1'b1, "R1 store strobe one cycle after write", st_we, 1);
         chk(st_row[DATA_W-1:0] == pats[p], "R2 data field verbatim", st_row[DATA_W-1:0], pats[p]);
         chk(st_row == ref_encode(pats[p]), "R3 check field layout", st_row, ref_encode(pats[p]));
         @(negedge clk);
         chk(st_we == 1'b0, "R1 store strobe drops", st_we, 0);
      end
   endtask

   task automatic test_clean_read();
      logic [DATA_W-1:0] d;
      d = 64'hDEAD_BEEF_0123_4567;
      do_read(ref_encode(d));
      chk(rd_valid == 1'b1, "R4 valid one cycle after read", rd_valid, 1);
      chk(rd_data == d && rd_corr == '0 && rd_uncorr == 0, "R4 clean read",
          {rd_data, rd_corr, rd_uncorr}, {d, 8'h00, 1'b0});
   endtask

   task automatic test_single();
      logic [DATA_W-1:0] d;
      logic [ROW_W-1:0] row;
      d = 64'h5A3C_96E1_0FF0_C33C;
      row = ref_encode(d);
      for (int i = 0; i < ROW_W; i++) begin
         logic [LANES-1:0] em;
         em = '0; em[i % LANES] = 1'b1;
         do_read(row ^ (ROW_W'(1) << i));
         chk(rd_data == d && rd_corr == em && rd_uncorr == 0, "R5 single flip corrected",
             {rd_data, rd_corr, rd_uncorr}, {d, em, 1'b0});
      end
   endtask

   task automatic test_bursts();
      logic [DATA_W-1:0] d;
      logic [ROW_W-1:0] row;
      d = 64'hC0FF_EE12_3456_789A;
      row = ref_encode(d);
      for (int len = 1; len <= LANES; len++) begin
         for (int s = 0; s + len <= ROW_W; s++) begin
            logic [ROW_W-1:0] m;
            logic [LANES-1:0] em;
            m = '0; em = '0;
            for (int b = 0; b < len; b++) begin
               m[s + b] = 1'b1;
               em[(s + b) % LANES] = 1'b1;
            end
            do_read(row ^ m);
            chk(rd_data == d && rd_corr == em && rd_uncorr == 0, "R6 burst corrected",
                {rd_data, rd_corr, rd_uncorr}, {d, em, 1'b0});
         end
      end
   endtask

   task automatic test_uncorr();
      logic [DATA_W-1:0] d;
      logic [ROW_W-1:0] row;
      d = 64'h1357_9BDF_2468_ACE0;
      row = ref_encode(d);
      for (int l = 2; l < LANES; l += 5) begin
         logic [ROW_W-1:0] m;
         logic [LANES-1:0] em;
         m = '0;
         m[DATA_W + 0*LANES + l] = 1'b1;
         m[DATA_W + 2*LANES + l] = 1'b1;
         m[DATA_W + 3*LANES + l] = 1'b1;
         // plus one correctable data flip in lane 0
         m[0] = 1'b1;
         em = 8'h01;
         do_read(row ^ m);
         chk(rd_uncorr == 1'b1, "R7 uncorrectable flagged", rd_uncorr, 1);
         chk(rd_corr == em, "R7 only other lane corrected", rd_corr, em);
         chk(rd_data == d, "R7 data of bad lane passed through", rd_data, d);
      end
   endtask

   task automatic test_idle();
      logic [DATA_W-1:0] held;
      do_read(ref_encode(64'h0F0F_F0F0_1234_8765) ^ (ROW_W'(1) << 5));
      held = rd_data;
      @(negedge clk);
      rd_row = '1;
      @(negedge clk);
      chk(rd_valid == 0 && rd_corr == '0 && rd_uncorr == 0, "R8 flags quiet when idle",
          {rd_valid, rd_corr, rd_uncorr}, 0);
      chk(rd_data == held, "R8 data holds when idle", rd_data, held);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_encode();
      test_clean_read();
      test_single();
      test_bursts();
      test_uncorr();
      test_idle();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule